// File: doc/BRIEF.md
# Cross Trigger Controller

This block routes debug trigger events between the local trigger lines of one core and a small set of broadcast channels. The channels are shared with the same controllers next to other cores. Each trigger input is connected to chosen channels through a per-input mask. Each trigger output listens to chosen channels through a per-output mask. A per-channel gate decides which channels exchange events with the shared matrix. Software can also inject a one-cycle event on any channel, and it can force trigger outputs high for integration testing.

Trigger outputs are sticky. Once a channel event sets one, it stays high until software writes an acknowledge for it, so it can act as a level interrupt. The configuration sits behind a software lock, which must be opened with a key before any register accepts a write. A typical use is cross-halt. Every core's halt-entered input and halt-request output are mapped to one channel, so a halt on any core requests a halt on all of them.

Top module: `xtrig_ctrl`

## Requirements
- R1: After reset all configuration registers are zero, the lock is closed, and `chan_out_o`, `trig_out_o` and `rdata_o` are zero.
- R2: The lock at offset 0xFB0 starts closed. While it is closed, writes to every other offset are ignored and the old values read back. Writing 0xC5ACCE55 there opens it, and writing any other value closes it again.
- R3: Bit 0 of the control register at 0x000 is the global enable. While it is 0, `chan_out_o` stays zero and no trigger input, channel input or pulse sets any trigger output.
- R4: The input mask of trigger input i is at 0x020+4*i. When its bit c is set and input i is high, channel c carries a local event in the same cycle.
- R5: The gate register at 0x140 holds one bit per channel. `chan_out_o[c]` is high only while gate bit c is set and channel c carries a local event. `chan_in_i[c]` is accepted only while gate bit c is set.
- R6: The output mask of trigger output j is at 0x0A0+4*j. If bit c is set and channel c carries a local or accepted event, `trig_out_o[j]` rises at the next clock edge. Local events reach the outputs whatever the gate holds.
- R7: A trigger output that has been set stays high until a write to 0x010 has a 1 in bit j. If a set and an acknowledge hit the same output in the same cycle, the set wins.
- R8: Writing bit c of 0x01C creates a local event on channel c during the cycle after the write. The mapped outputs rise one edge later.
- R9: Bit j of the register at 0xEE8 drives `trig_out_o[j]` high directly, whatever the enable and mapping hold.
- R10: A read returns its data on `rdata_o` one cycle after the request. Mask registers read back their low channel bits. The pulse, acknowledge and lock offsets and unmapped offsets read as zero.
- R11: With several trigger inputs and outputs mapped to one channel, a pulse on any one of those inputs sets all of those outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after the read |
| trig_in_i | input | N_TI | Trigger inputs from the core |
| trig_out_o | output | N_TO | Sticky trigger outputs |
| chan_in_i | input | N_CH | Channel events from the matrix |
| chan_out_o | output | N_CH | Channel events toward the matrix |

## Verification
The checks assume that every bus access lasts exactly one cycle and that addresses are word aligned. The bench drives all of its accesses through single-cycle tasks that enforce this. The sticky-output property assumes that the trigger registers start at zero when reset is released, so reset is held for several edges before any stimulus is applied. Trigger and channel inputs are changed only on the falling clock edge. Each input is held for exactly one rising edge, so the bench knows in which cycle an output should set.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int OFS_CTRL  = 'h000;
  localparam int OFS_ACK   = 'h010;
  localparam int OFS_PULSE = 'h01C;
  localparam int OFS_INEN  = 'h020;
  localparam int OFS_OUTEN = 'h0A0;
  localparam int OFS_GATE  = 'h140;
  localparam int OFS_ITOUT = 'hEE8;
  localparam int OFS_LOCK  = 'hFB0;
  localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int N_TI   = 8,
  parameter int N_TO   = 8,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  output logic                       en_o,
  output logic [N_CH-1:0]            gate_o,
  output logic [N_TI-1:0][N_CH-1:0]  in_en_o,
  output logic [N_TO-1:0][N_CH-1:0]  out_en_o,
  output logic [N_TO-1:0]            itout_o,
  output logic [N_CH-1:0]            pulse_o,
  output logic [N_TO-1:0]            ack_o,
  output logic                       locked_o
);
  logic wr, rd, wr_ok;
  logic hit_ctrl, hit_ack, hit_pulse, hit_gate, hit_itout, hit_lock;
  logic [N_TI-1:0] hit_in;
  logic [N_TO-1:0] hit_out;
  logic locked_q, en_q;
  logic [N_CH-1:0] gate_q, pulse_q;
  logic [N_TO-1:0] itout_q;
  logic [N_TI-1:0][N_CH-1:0] in_en_q;
  logic [N_TO-1:0][N_CH-1:0] out_en_q;
  logic [31:0] rd_val, rdata_q;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wr_ok = wr & ~locked_q;

  assign hit_ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_ack   = (addr_i == ADDR_W'(OFS_ACK));
  assign hit_pulse = (addr_i == ADDR_W'(OFS_PULSE));
  assign hit_gate  = (addr_i == ADDR_W'(OFS_GATE));
  assign hit_itout = (addr_i == ADDR_W'(OFS_ITOUT));
  assign hit_lock  = (addr_i == ADDR_W'(OFS_LOCK));

  for (genvar i = 0; i < N_TI; i++) begin : g_in
    assign hit_in[i] = (addr_i == ADDR_W'(OFS_INEN + 4*i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 in_en_q[i] <= '0;
      else if (wr_ok && hit_in[i]) in_en_q[i] <= wdata_i[N_CH-1:0];
    end
  end

  for (genvar j = 0; j < N_TO; j++) begin : g_out
    assign hit_out[j] = (addr_i == ADDR_W'(OFS_OUTEN + 4*j));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  out_en_q[j] <= '0;
      else if (wr_ok && hit_out[j]) out_en_q[j] <= wdata_i[N_CH-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
      en_q     <= 1'b0;
      gate_q   <= '0;
      itout_q  <= '0;
      pulse_q  <= '0;
    end else begin
      if (wr && hit_lock)       locked_q <= (wdata_i != UNLOCK_KEY);
      if (wr_ok && hit_ctrl)    en_q     <= wdata_i[0];
      if (wr_ok && hit_gate)    gate_q   <= wdata_i[N_CH-1:0];
      if (wr_ok && hit_itout)   itout_q  <= wdata_i[N_TO-1:0];
      // self-clearing: one cycle of channel event per write
      pulse_q <= (wr_ok && hit_pulse) ? wdata_i[N_CH-1:0] : '0;
    end
  end

  assign ack_o = (wr_ok && hit_ack) ? wdata_i[N_TO-1:0] : '0;

  always_comb begin
    rd_val = '0;
    if (hit_ctrl)  rd_val[0]        = en_q;
    if (hit_gate)  rd_val[N_CH-1:0] = gate_q;
    if (hit_itout) rd_val[N_TO-1:0] = itout_q;
    for (int i = 0; i < N_TI; i++)
      if (hit_in[i]) rd_val[N_CH-1:0] = in_en_q[i];
    for (int j = 0; j < N_TO; j++)
      if (hit_out[j]) rd_val[N_CH-1:0] = out_en_q[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o  = rdata_q;
  assign en_o     = en_q;
  assign gate_o   = gate_q;
  assign in_en_o  = in_en_q;
  assign out_en_o = out_en_q;
  assign itout_o  = itout_q;
  assign pulse_o  = pulse_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
  parameter int N_TI = 8,
  parameter int N_CH = 4
) (
  input  logic                      en_i,
  input  logic [N_CH-1:0]           gate_i,
  input  logic [N_TI-1:0][N_CH-1:0] in_en_i,
  input  logic [N_CH-1:0]           pulse_i,
  input  logic [N_TI-1:0]           trig_in_i,
  input  logic [N_CH-1:0]           chan_in_i,
  output logic [N_CH-1:0]           chan_out_o,
  output logic [N_CH-1:0]           chan_evt_o
);
  logic [N_CH-1:0][N_TI-1:0] tap;
  logic [N_CH-1:0] local_evt;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    for (genvar i = 0; i < N_TI; i++) begin : g_tap
      assign tap[c][i] = trig_in_i[i] & in_en_i[i][c];
    end
    assign local_evt[c] = (|tap[c]) | pulse_i[c];
  end

  // gate only filters traffic to and from the matrix
  assign chan_out_o = {N_CH{en_i}} & gate_i & local_evt;
  assign chan_evt_o = {N_CH{en_i}} & (local_evt | (gate_i & chan_in_i));
endmodule

// File: rtl/xtrig_latch.sv
module xtrig_latch #(
  parameter int N_TO = 8,
  parameter int N_CH = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CH-1:0]           chan_evt_i,
  input  logic [N_TO-1:0][N_CH-1:0] out_en_i,
  input  logic [N_TO-1:0]           ack_i,
  input  logic [N_TO-1:0]           itout_i,
  output logic [N_TO-1:0]           trig_q_o,
  output logic [N_TO-1:0]           trig_out_o
);
  logic [N_TO-1:0] set, trig_q;

  for (genvar j = 0; j < N_TO; j++) begin : g_set
    assign set[j] = |(chan_evt_i & out_en_i[j]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else         trig_q <= (trig_q & ~ack_i) | set;  // set beats ack
  end

  assign trig_q_o   = trig_q;
  assign trig_out_o = trig_q | itout_i;
endmodule

// File: rtl/xtrig_ctrl.sv
module xtrig_ctrl #(
  parameter int N_TI   = 8,
  parameter int N_TO   = 8,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_TI-1:0]   trig_in_i,
  output logic [N_TO-1:0]   trig_out_o,
  input  logic [N_CH-1:0]   chan_in_i,
  output logic [N_CH-1:0]   chan_out_o
);
  logic                      ctrl_en, locked;
  logic [N_CH-1:0]           gate, pulse, chan_evt;
  logic [N_TI-1:0][N_CH-1:0] in_en;
  logic [N_TO-1:0][N_CH-1:0] out_en;
  logic [N_TO-1:0]           itout, ack, trig_q;

  xtrig_regs #(.N_TI(N_TI), .N_TO(N_TO), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .en_o(ctrl_en), .gate_o(gate), .in_en_o(in_en), .out_en_o(out_en),
    .itout_o(itout), .pulse_o(pulse), .ack_o(ack), .locked_o(locked)
  );

  xtrig_route #(.N_TI(N_TI), .N_CH(N_CH)) u_route (
    .en_i(ctrl_en), .gate_i(gate), .in_en_i(in_en), .pulse_i(pulse),
    .trig_in_i, .chan_in_i, .chan_out_o, .chan_evt_o(chan_evt)
  );

  xtrig_latch #(.N_TO(N_TO), .N_CH(N_CH)) u_latch (
    .clk_i, .rst_ni, .chan_evt_i(chan_evt), .out_en_i(out_en),
    .ack_i(ack), .itout_i(itout), .trig_q_o(trig_q), .trig_out_o
  );
endmodule

// File: rtl/xtrig_ctrl_sva.sv
module xtrig_ctrl_sva
  import xtrig_pkg::*;
#(
  parameter int N_TO   = 8,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic [N_TO-1:0]   trig_out_o,
  input logic [N_CH-1:0]   chan_out_o,
  input logic              en_i,
  input logic              locked_i,
  input logic [N_CH-1:0]   gate_i,
  input logic [N_TO-1:0]   itout_i,
  input logic [N_TO-1:0]   trig_q_i,
  input logic [N_TO-1:0]   ack_i
);
  p_disabled_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> chan_out_o == '0);

  p_gate_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_out_o & ~gate_i) == '0);

  p_itout_force_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_out_o & itout_i) == itout_i);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q_i & ~ack_i) != '0 |=>
      (trig_q_i & $past(trig_q_i & ~ack_i)) == $past(trig_q_i & ~ack_i));

  p_locked_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i && req_i && we_i && addr_i == ADDR_W'(OFS_CTRL) |=> $stable(en_i));

  p_rd_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == ADDR_W'(OFS_PULSE) |=> rdata_o == '0);
endmodule

bind xtrig_ctrl xtrig_ctrl_sva #(.N_TO(N_TO), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .trig_out_o(trig_out_o), .chan_out_o(chan_out_o),
  .en_i(ctrl_en), .locked_i(locked), .gate_i(gate), .itout_i(itout),
  .trig_q_i(trig_q), .ack_i(ack)
);

// File: tb/xtrig_ctrl_tb_top.sv
module xtrig_ctrl_tb_top;
  localparam logic [11:0] A_CTRL = 12'h000, A_ACK = 12'h010, A_PULSE = 12'h01C,
                          A_INEN = 12'h020, A_OUTEN = 12'h0A0, A_GATE = 12'h140,
                          A_ITOUT = 12'hEE8, A_LOCK = 12'hFB0;
  localparam logic [31:0] KEY = 32'hC5AC_CE55;

  typedef struct packed {
    logic [7:0] ti; logic [3:0] ci; logic [3:0] co; logic [7:0] to;
  } vec_t;
  // config: gate=0101, in i -> ch i%4, out j <- ch j%4
  localparam vec_t VEC [7] = '{
    '{8'h01, 4'h0, 4'h1, 8'h11},
    '{8'h02, 4'h0, 4'h0, 8'h22},
    '{8'h00, 4'hF, 4'h0, 8'h55},
    '{8'h80, 4'h2, 4'h0, 8'h88},
    '{8'h44, 4'h0, 4'h4, 8'h44},
    '{8'h00, 4'h0, 4'h0, 8'h00},
    '{8'h30, 4'h1, 4'h1, 8'h33}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic [7:0] tin = '0, tout;
  logic [3:0] cin = '0, cout;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xtrig_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .trig_in_i(tin), .trig_out_o(tout),
    .chan_in_i(cin), .chan_out_o(cout)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 chan_out", 32'(cout), 0);
    chk("R1 trig_out", 32'(tout), 0);
    chk("R1 rdata", rdata, 0);

    // lock behaviour
    wr(A_CTRL, 1); rd(A_CTRL, rv); chk("R2 locked write", rv, 0);
    wr(A_INEN, 32'hF); rd(A_INEN, rv); chk("R2 locked inen", rv, 0);
    wr(A_LOCK, KEY); wr(A_CTRL, 1); rd(A_CTRL, rv); chk("R2 unlocked write", rv, 1);
    wr(A_LOCK, 0); wr(A_CTRL, 0); rd(A_CTRL, rv); chk("R2 relocked", rv, 1);
    wr(A_LOCK, KEY);

    // read side
    wr(A_INEN + 12'd12, 32'hFFFF_FFFF); rd(A_INEN + 12'd12, rv); chk("R10 mask readback", rv, 32'hF);
    rd(A_PULSE, rv); chk("R10 pulse reads 0", rv, 0);
    rd(A_LOCK, rv);  chk("R10 lock reads 0", rv, 0);
    rd(12'h300, rv); chk("R10 unmapped reads 0", rv, 0);

    // configuration for the vector table
    wr(A_GATE, 32'h5);
    for (int i = 0; i < 8; i++) wr(A_INEN + 12'(4*i), 32'(1 << (i % 4)));
    for (int j = 0; j < 8; j++) wr(A_OUTEN + 12'(4*j), 32'(1 << (j % 4)));
    rd(A_GATE, rv); chk("R5 gate readback", rv, 32'h5);

    // R4 R5 R6: routing table
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); tin = VEC[k].ti; cin = VEC[k].ci;
      #1 chk("R4 R5 chan_out", 32'(cout), 32'(VEC[k].co));
      @(negedge clk); chk("R6 trig_out", 32'(tout), 32'(VEC[k].to));
      tin = '0; cin = '0;
      wr(A_ACK, 32'hFF);
    end

    // R8: application pulse
    wr(A_PULSE, 32'h4);
    #1 chk("R8 pulse chan_out", 32'(cout), 32'h4);
    @(negedge clk); chk("R8 pulse trig_out", 32'(tout), 32'h44);
    chk("R8 pulse self-clears", 32'(cout), 0);
    wr(A_ACK, 32'hFF);
    wr(A_PULSE, 32'h2);
    #1 chk("R8 ungated pulse chan_out", 32'(cout), 0);
    @(negedge clk); chk("R8 ungated pulse trig_out", 32'(tout), 32'h22);
    wr(A_ACK, 32'hFF);

    // R7: sticky outputs
    @(negedge clk); tin = 8'h01;
    @(negedge clk); tin = 8'h00;
    repeat (3) @(negedge clk);
    chk("R7 held", 32'(tout), 32'h11);
    wr(A_ACK, 32'h01); chk("R7 ack one bit", 32'(tout), 32'h10);
    wr(A_ACK, 32'h10); chk("R7 ack rest", 32'(tout), 0);
    @(negedge clk); tin = 8'h01;
    wr(A_ACK, 32'h11); chk("R7 set beats ack", 32'(tout), 32'h11);
    tin = 8'h00;
    wr(A_ACK, 32'hFF); chk("R7 cleared", 32'(tout), 0);

    // R11: cross-halt on channel 3
    wr(A_INEN + 12'd4, 32'h8); wr(A_INEN + 12'd8, 32'h8);
    for (int j = 0; j < 3; j++) wr(A_OUTEN + 12'(4*j), 32'h8);
    @(negedge clk); tin = 8'h04;
    #1 chk("R11 ungated channel stays local", 32'(cout), 0);
    @(negedge clk); tin = 8'h00; chk("R11 halt from core 2", 32'(tout), 32'h8F);
    wr(A_ACK, 32'hFF);
    @(negedge clk); tin = 8'h02;
    @(negedge clk); tin = 8'h00; chk("R11 halt from core 1", 32'(tout), 32'h8F);
    wr(A_ACK, 32'hFF);

    // R3: global enable off
    wr(A_CTRL, 0);
    @(negedge clk); tin = 8'hFF; cin = 4'hF;
    #1 chk("R3 chan_out off", 32'(cout), 0);
    @(negedge clk); tin = '0; cin = '0; chk("R3 trig_out off", 32'(tout), 0);
    wr(A_PULSE, 32'hF);
    @(negedge clk); chk("R3 pulse blocked", 32'(tout), 0);

    // R9: integration override
    wr(A_ITOUT, 32'h81); chk("R9 forced", 32'(tout), 32'h81);
    wr(A_ITOUT, 0); chk("R9 released", 32'(tout), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule